// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller organised in banks of 32 pins. For every pin it keeps an output value and a drive enable, and it samples the pad through a two-stage synchronizer so software can read the pad level. Each pin can raise an interrupt. Three independent per-pin bit-planes set how it senses: level or edge, single or dual edge, and active-high/rising or active-low/falling.

Every bank has its own latched (raw) status, enable mask, masked status and write-one-to-clear registers. A plain 32-bit register bus with address, write strobe, write data and combinational read data reaches all registers. Bank `n` occupies the window starting at `n * 0x200`. A single interrupt line, registered once, reports whether any enabled status bit is set in any bank.

Top module: `gpx_ctrl`

## Requirements
- R1: Pin p lives in bank p/32 at bit p%32. Bank n's registers start at byte address n*0x200. Within a bank the byte offsets are 0x00 pad input, 0x04 output value, 0x08 drive enable, 0x0C sense type, 0x10 dual edge, 0x14 polarity, 0x18 mask, 0x1C raw status, 0x20 masked status and 0x24 clear. Bank-select values of NUM_BANKS or more address nothing.
- R2: After reset every register reads zero, no pin is driven (`pad_oe` all 0), `pad_out` is 0 and `irq` is 0.
- R3: A pin's drive-enable bit of 1 asserts its `pad_oe` bit, and the pin's output-value bit appears on `pad_out`. Both registers read back what was written.
- R4: The pad input register returns `pad_in` delayed by two clock edges (two-flop synchronizer), regardless of the drive enable.
- R5: With sense type 0 (edge) and dual edge 0, a polarity bit of 1 latches raw status on a rising pad edge and 0 latches it on a falling edge. Status is latched on the third clock edge after the pad changes.
- R6: With sense type 0 and dual edge 1, both rising and falling edges latch status, whatever the polarity bit.
- R7: With sense type 1 (level), polarity 1 makes a high pad active and 0 makes a low pad active. Status is set on every cycle the active level persists, so a clear only sticks once the level goes inactive.
- R8: Writing 1 to a bit of the clear register clears that raw status bit, and writing 0 leaves it alone. If a new event and a clear hit the same bit in the same cycle, the bit stays set. A raw bit only becomes set through an event.
- R9: The masked status register reads raw status AND mask, where a mask bit of 1 enables the pin.
- R10: `irq` is the OR of every bank's masked status, registered, so it follows a change of mask or status one clock edge later.
- R11: Writes to the pad input, raw status and masked status registers are ignored. The clear register reads 0, unmapped offsets and absent banks read 0, and a write to an absent bank changes no bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_BANKS*32 | Pad levels seen by the controller |
| pad_out | output | NUM_BANKS*32 | Value each pin drives when enabled |
| pad_oe | output | NUM_BANKS*32 | Per-pin drive enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bound checker watches several properties on every cycle. Every raw status bit that rises must be backed by a sense event in the previous cycle. Every event must leave its bit set, even against a simultaneous clear. An edge-sensed event must coincide with a change of the synchronized sample. `irq` must only rise when some masked status bit was set a cycle earlier, the drive enables must hold between writes, and reset must leave no pin driven. The address decode, the two-cycle input latency, the precise semantics of each of the five sense modes in both banks, level re-latching after a clear, and the one-cycle `irq` lag after a mask write only show up in the bench's directed sweeps, which compare read data and port values against values derived from the requirements.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int PINS_PER_BANK = 32;
    localparam int STRIDE_LOG2   = 9;   // 0x200 bytes per bank
    localparam int OFS_W         = STRIDE_LOG2;

    typedef logic [PINS_PER_BANK-1:0] pinvec_t;

    // byte offsets inside one bank window; software decodes these
    typedef enum logic [OFS_W-1:0] {
        RG_DIN   = 9'h000,
        RG_DOUT  = 9'h004,
        RG_OE    = 9'h008,
        RG_LTYPE = 9'h00C,
        RG_DUAL  = 9'h010,
        RG_POL   = 9'h014,
        RG_MASK  = 9'h018,
        RG_RAW   = 9'h01C,
        RG_MSTAT = 9'h020,
        RG_CLR   = 9'h024
    } reg_ofs_e;

    // writable per-bank state
    typedef struct packed {
        pinvec_t dout;
        pinvec_t oe;
        pinvec_t ltype;
        pinvec_t dual;
        pinvec_t pol;
        pinvec_t mask;
    } bank_cfg_t;

    // one pin's sense decision from the current and previous synchronized sample
    function automatic logic pin_event(input logic ltype, input logic dual,
                                       input logic pol, input logic cur,
                                       input logic prev);
        logic ev;
        if (ltype)
            ev = pol ? cur : ~cur;
        else if (dual)
            ev = cur ^ prev;
        else if (pol)
            ev = cur & ~prev;
        else
            ev = ~cur & prev;
        return ev;
    endfunction

    // read data of one bank for a given offset
    function automatic pinvec_t read_word(input logic [OFS_W-1:0] ofs,
                                         input bank_cfg_t cfg,
                                         input pinvec_t din,
                                         input pinvec_t raw);
        pinvec_t v;
        case (ofs)
            RG_DIN:   v = din;
            RG_DOUT:  v = cfg.dout;
            RG_OE:    v = cfg.oe;
            RG_LTYPE: v = cfg.ltype;
            RG_DUAL:  v = cfg.dual;
            RG_POL:   v = cfg.pol;
            RG_MASK:  v = cfg.mask;
            RG_RAW:   v = raw;
            RG_MSTAT: v = raw & cfg.mask;
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/gpx_sense.sv
module gpx_sense
    import gpx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pinvec_t cur,
    input  pinvec_t ltype,
    input  pinvec_t dual,
    input  pinvec_t pol,
    output pinvec_t ev
);
    pinvec_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= cur;
    end

    for (genvar i = 0; i < PINS_PER_BANK; i++) begin : g_pin
        assign ev[i] = pin_event(ltype[i], dual[i], pol[i], cur[i], prev[i]);
    end
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
    import gpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] ofs,
    input  pinvec_t          wdata,
    input  pinvec_t          din,
    output bank_cfg_t        cfg,
    output pinvec_t          raw,
    output pinvec_t          ev
);
    pinvec_t clr_bits;

    gpx_sense u_sense (
        .clk   (clk),
        .rst   (rst),
        .cur   (din),
        .ltype (cfg.ltype),
        .dual  (cfg.dual),
        .pol   (cfg.pol),
        .ev    (ev)
    );

    always_comb begin
        clr_bits = '0;
        if (wr_en && ofs == RG_CLR) clr_bits = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            raw <= '0;
        end else begin
            if (wr_en) begin
                case (ofs)
                    RG_DOUT:  cfg.dout  <= wdata;
                    RG_OE:    cfg.oe    <= wdata;
                    RG_LTYPE: cfg.ltype <= wdata;
                    RG_DUAL:  cfg.dual  <= wdata;
                    RG_POL:   cfg.pol   <= wdata;
                    RG_MASK:  cfg.mask  <= wdata;
                    default: ;
                endcase
            end
            // a fresh event outranks a clear of the same bit
            raw <= (raw & ~clr_bits) | ev;
        end
    end
endmodule

// File: rtl/gpx_ctrl.sv
module gpx_ctrl
    import gpx_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic                              bus_we,
    input  logic [31:0]                       bus_wdata,
    output logic [31:0]                       bus_rdata,
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_in,
    output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_out,
    output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_oe,
    output logic                              irq
);
    localparam int NP    = NUM_BANKS * PINS_PER_BANK;
    localparam int SEL_W = ADDR_W - STRIDE_LOG2;

    logic [NP-1:0]    sync_all;
    logic [NP-1:0]    ev_all;
    logic [NP-1:0]    raw_all;
    logic [NP-1:0]    mask_all;
    logic [NP-1:0]    type_all;
    logic [SEL_W-1:0] bsel;
    logic [OFS_W-1:0] ofs;
    pinvec_t          rd_arr [NUM_BANKS];
    logic             irq_q;

    assign bsel = bus_addr[ADDR_W-1:STRIDE_LOG2];
    assign ofs  = bus_addr[STRIDE_LOG2-1:0];

    gpx_sync #(.W(NP)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (sync_all)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_cfg_t cfg;
        pinvec_t   raw;
        pinvec_t   ev;
        logic      wr_sel;

        assign wr_sel = bus_we && (bsel == SEL_W'(b));

        gpx_bank u_bank (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_sel),
            .ofs   (ofs),
            .wdata (bus_wdata),
            .din   (sync_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .cfg   (cfg),
            .raw   (raw),
            .ev    (ev)
        );

        assign pad_out [b*PINS_PER_BANK +: PINS_PER_BANK] = cfg.dout;
        assign pad_oe  [b*PINS_PER_BANK +: PINS_PER_BANK] = cfg.oe;
        assign raw_all [b*PINS_PER_BANK +: PINS_PER_BANK] = raw;
        assign ev_all  [b*PINS_PER_BANK +: PINS_PER_BANK] = ev;
        assign mask_all[b*PINS_PER_BANK +: PINS_PER_BANK] = cfg.mask;
        assign type_all[b*PINS_PER_BANK +: PINS_PER_BANK] = cfg.ltype;
        assign rd_arr[b] = read_word(ofs, cfg,
                                     sync_all[b*PINS_PER_BANK +: PINS_PER_BANK], raw);
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (bsel == SEL_W'(b)) bus_rdata = rd_arr[b];
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(raw_all & mask_all);
    end

    assign irq = irq_q;
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker #(
    parameter int NP = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_we,
    input logic [NP-1:0] pad_oe,
    input logic          irq,
    input logic [NP-1:0] ev_all,
    input logic [NP-1:0] raw_all,
    input logic [NP-1:0] mask_all,
    input logic [NP-1:0] type_all,
    input logic [NP-1:0] sync_all
);
    // R2: the first cycle out of reset drives nothing and requests nothing
    a_r2_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && pad_oe == '0));

    // R3: drive enables only move after a write
    a_r3_oe_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_we) |-> $stable(pad_oe));

    // R5: an edge-sensed event needs a change of the synchronized sample
    a_r5_edge_needs_change: assert property (@(posedge clk) disable iff (rst)
        ((ev_all & ~type_all & ~(sync_all ^ $past(sync_all))) == '0));

    // R8: an event always lands, even against a clear
    a_r8_event_lands: assert property (@(posedge clk) disable iff (rst)
        (ev_all != '0) |=> ((raw_all & $past(ev_all)) == $past(ev_all)));

    // R8: raw status only rises through an event
    a_r8_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        ((raw_all & ~$past(raw_all) & ~$past(ev_all)) == '0));

    // R10: the interrupt only rises from an enabled status bit
    a_r10_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(raw_all & mask_all) != '0));
endmodule

bind gpx_ctrl gpx_checker #(.NP(NP)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .pad_oe   (pad_oe),
    .irq      (irq),
    .ev_all   (ev_all),
    .raw_all  (raw_all),
    .mask_all (mask_all),
    .type_all (type_all),
    .sync_all (sync_all)
);

// File: tb/gpx_ctrl_bench.sv
module gpx_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 2;
    localparam int NP = NB * 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpx_ctrl #(.NUM_BANKS(NB), .ADDR_W(16)) u_gpx_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called at a negedge; sampled on the next posedge; returns at the following negedge
    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic clear_cfg(input logic [15:0] base);
        wr(base + 16'h0C, 32'h0);
        wr(base + 16'h10, 32'h0);
        wr(base + 16'h14, 32'h0);
        wr(base + 16'h18, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        step(3);
        rst = 1'b0;
        step(1);

        // R2: reset state of every register in both banks and of the outputs
        for (int b = 0; b < NB; b++)
            for (int o = 0; o <= 'h24; o += 4) begin
                rd(16'(b * 'h200 + o), v);
                chk("R2 reset register", {32'h0, v}, 64'h0);
            end
        chk("R2 pad_oe", pad_oe, 64'h0);
        chk("R2 pad_out", pad_out, 64'h0);
        chk("R2 irq", {63'h0, irq}, 64'h0);

        // R1 R3: bank 1 output and drive enable
        wr(16'h0204, 32'hA5A5_0F0F);
        wr(16'h0208, 32'hFFFF_0000);
        chk("R3 pad_out bank1", pad_out, 64'hA5A5_0F0F_0000_0000);
        chk("R1 R3 pad_oe bank1", pad_oe, 64'hFFFF_0000_0000_0000);
        rd(16'h0204, v);
        chk("R3 dout readback", {32'h0, v}, 64'hA5A5_0F0F);
        rd(16'h0004, v);
        chk("R1 bank0 dout untouched", {32'h0, v}, 64'h0);

        // R11: absent bank and read-only registers
        wr(16'h0404, 32'hFFFF_FFFF);
        chk("R11 absent bank write", pad_out, 64'hA5A5_0F0F_0000_0000);
        rd(16'h0404, v);
        chk("R11 absent bank read", {32'h0, v}, 64'h0);
        rd(16'h0028, v);
        chk("R11 unmapped offset", {32'h0, v}, 64'h0);

        // R4: two-edge input latency, independent of drive enable
        pad_in = 64'h1234_5678_9ABC_DEF0;
        step(1);
        rd(16'h0000, v);
        chk("R4 din after one edge", {32'h0, v}, 64'h0);
        step(1);
        rd(16'h0000, v);
        chk("R4 din bank0", {32'h0, v}, 64'h9ABC_DEF0);
        rd(16'h0200, v);
        chk("R4 din bank1 driven", {32'h0, v}, 64'h1234_5678);
        wr(16'h0000, 32'h0);
        rd(16'h0000, v);
        chk("R11 din write ignored", {32'h0, v}, 64'h9ABC_DEF0);

        pad_in = '0;
        step(4);
        wr(16'h0024, 32'hFFFF_FFFF);
        wr(16'h0224, 32'hFFFF_FFFF);
        wr(16'h001C, 32'hFFFF_FFFF);
        rd(16'h001C, v);
        chk("R11 raw write ignored", {32'h0, v}, 64'h0);
        rd(16'h0024, v);
        chk("R11 clear reads zero", {32'h0, v}, 64'h0);

        // R5 R6 R7 R9 R10: sweep of the five sense modes over both banks
        for (int b = 0; b < NB; b++)
            for (int m = 0; m < 5; m++) begin
                int          p;
                logic        t, d, pl;
                logic [31:0] bt;
                logic [15:0] base, ob;
                string       tag;
                p    = (m * 11 + b * 5 + 3) % 32;
                t    = (m >= 3);
                d    = (m == 2);
                pl   = (m == 0 || m == 3);
                bt   = 32'h1 << p;
                base = 16'(b * 'h200);
                ob   = base ^ 16'h0200;
                tag  = t ? "R7 level" : (d ? "R6 dual edge" : "R5 single edge");

                pad_in = '0;
                step(4);
                clear_cfg(ob);
                clear_cfg(base);
                wr(base + 16'h0C, t ? bt : 32'h0);
                wr(base + 16'h10, d ? bt : 32'h0);
                wr(base + 16'h14, pl ? bt : 32'h0);
                wr(base + 16'h18, bt);
                step(2);
                wr(base + 16'h24, 32'hFFFF_FFFF);
                wr(ob + 16'h24, 32'hFFFF_FFFF);
                step(1);
                rd(base + 16'h1C, v);
                chk({tag, " idle low"}, {32'h0, v}, {32'h0, (t & ~pl) ? bt : 32'h0});

                pad_in[b*32 + p] = 1'b1;
                step(4);
                rd(base + 16'h1C, v);
                chk({tag, " after rise"}, {32'h0, v}, {32'h0, (t | d | pl) ? bt : 32'h0});
                rd(base + 16'h20, v);
                chk("R9 masked status", {32'h0, v}, {32'h0, (t | d | pl) ? bt : 32'h0});
                chk("R10 irq from pin", {63'h0, irq}, {63'h0, (t | d | pl)});
                rd(ob + 16'h1C, v);
                chk("R1 other bank quiet", {32'h0, v}, 64'h0);

                wr(base + 16'h24, bt);
                step(1);
                rd(base + 16'h1C, v);
                chk({tag, " clear while high"}, {32'h0, v}, {32'h0, (t & pl) ? bt : 32'h0});

                pad_in[b*32 + p] = 1'b0;
                step(4);
                rd(base + 16'h1C, v);
                chk({tag, " after fall"}, {32'h0, v}, {32'h0, (t | d | ~pl) ? bt : 32'h0});

                wr(base + 16'h24, bt);
                step(1);
                rd(base + 16'h1C, v);
                chk({tag, " clear while low"}, {32'h0, v}, {32'h0, (t & ~pl) ? bt : 32'h0});
            end

        // R8: clear semantics and event-over-clear priority, bank 0 pins 7 and 20 dual edge
        pad_in = '0;
        step(4);
        clear_cfg(16'h0200);
        clear_cfg(16'h0000);
        wr(16'h0010, 32'h0010_0080);
        step(2);
        wr(16'h0024, 32'hFFFF_FFFF);
        wr(16'h0224, 32'hFFFF_FFFF);
        pad_in[7]  = 1'b1;
        pad_in[20] = 1'b1;
        step(4);
        rd(16'h001C, v);
        chk("R8 two pins latched", {32'h0, v}, 64'h0010_0080);
        pad_in[7] = 1'b0;
        step(2);
        wr(16'h0024, 32'h0000_0080);
        rd(16'h001C, v);
        chk("R8 event beats clear", {32'h0, v}, 64'h0010_0080);
        wr(16'h0024, 32'h0);
        rd(16'h001C, v);
        chk("R8 write zero to clear", {32'h0, v}, 64'h0010_0080);
        wr(16'h0024, 32'h0000_0080);
        rd(16'h001C, v);
        chk("R8 partial clear", {32'h0, v}, 64'h0010_0000);

        // R10: registered interrupt follows the mask one edge later
        chk("R10 irq masked off", {63'h0, irq}, 64'h0);
        wr(16'h0018, 32'h0010_0000);
        chk("R10 irq not yet", {63'h0, irq}, 64'h0);
        step(1);
        chk("R10 irq one edge later", {63'h0, irq}, 64'h1);
        rd(16'h0020, v);
        chk("R9 masked after unmask", {32'h0, v}, 64'h0010_0000);
        wr(16'h0024, 32'h0010_0000);
        step(1);
        chk("R10 irq drops after clear", {63'h0, irq}, 64'h0);

        // R10: bank 1 alone raises the shared line
        wr(16'h0214, 32'h0000_0001);
        wr(16'h0218, 32'h0000_0001);
        pad_in[32] = 1'b1;
        step(5);
        chk("R10 irq from bank1", {63'h0, irq}, 64'h1);
        rd(16'h0020, v);
        chk("R9 bank0 masked clear", {32'h0, v}, 64'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule